// File: doc/BRIEF.md
# Key-Protected Control Register Bank

This block is a bank of 32-bit control registers on a simple register bus. Most of its registers can only be changed after software has opened a software lock. The lock is set and cleared by writing fixed 16-bit key values to two dedicated write-only locations. While the bank is locked, writes to general registers are dropped without an error. A one-bit scratch register at offset 0x000 stays writable at all times.

Each byte offset belongs to one class: read-write, read-only, write-only or unmapped. The block reports an error for an access that its class does not allow. It also reports an error for an address that is not word aligned. A write that sets bit 0 of the reset-control register while the bank is open produces a one-cycle soft-reset request. Downstream reset logic uses that request.

Requests carry `req_valid`, `req_write`, `req_addr` and `req_wdata`. The block accepts a request in every cycle and never applies back-pressure, so it has no ready signal. Each request gets exactly one response on the next cycle. The response is `rsp_valid` together with `rsp_rdata` and `rsp_err`. A write takes effect at the clock edge that accepts it, so a read issued in the following cycle returns the new value.

Top module: `ctl_keyed_regbank`

## Requirements
- R1: After reset the bank is locked. The three PLL control registers (0x100, 0x104, 0x108) read 0x0001A008, the UART clock control (0x154) reads 0x00003F03, and the reset control (0x200), the scratch bit (0x000) and the general registers at 0x700 + 4*i read 0. `rsp_valid` and `soft_rst_req` are low.
- R2: A request accepted in cycle N is answered with `rsp_valid` high in cycle N+1. `rsp_valid` is low in the cycle after a cycle with no request.
- R3: A write to 0x004 whose low 16 bits equal 0x767B sets the lock, whatever its upper 16 bits hold. Any other value written there leaves the lock unchanged.
- R4: A write to 0x008 whose low 16 bits equal 0xDF0D clears the lock, whatever its upper 16 bits hold. Any other value written there leaves the lock unchanged.
- R5: Reading 0x00C returns the lock state in bit 0 (1 = locked) and zero in all other bits.
- R6: While the bank is locked, a write to any read-write register other than 0x000 is dropped without an error, and the stored value is unchanged.
- R7: A write to 0x000 stores only bit 0 of the data, and it is accepted whether the bank is locked or not. A read returns that bit, with bits 31:1 reading zero.
- R8: 0x004, 0x008, 0x60C and 0x614 are write-only. Reading any of them sets `rsp_err` and returns zero. Writing 0x60C or 0x614 has no visible effect.
- R9: 0x00C, 0x10C, 0x25C and 0x530 are read-only. 0x10C reads 0x0000003F, 0x25C reads 0x00000001, and 0x530 reads the ID_VALUE parameter. A write to any of them sets `rsp_err` and changes nothing.
- R10: An access to any offset outside the map sets `rsp_err`. A read of such an offset returns zero, and a write to it changes no register.
- R11: A write to 0x200 with bit 0 set while the bank is unlocked raises `soft_rst_req` for exactly the response cycle and stores the value. No other register changes. While the bank is locked, such a write raises no request.
- R12: An address with either of bits 1:0 set is treated as unmapped. It sets `rsp_err` and returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte address of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data; zero for writes and failed reads |
| rsp_err | output | 1 | Access not allowed for that offset |
| soft_rst_req | output | 1 | One-cycle soft-reset request |

## Verification
A wrong lock state shows up as soon as the next access. A locked bank with a wrong lock flag would accept or drop a PLL control write, and the following read returns the wrong value. Reading 0x00C exposes the flag directly. A wrong class decode shows as an `rsp_err` mismatch or a non-zero read in the very next cycle. A wrong stored value shows on the first read of that register. The random phase interleaves key writes with general writes, so the lock flips many times across the run and each flip is checked against a bench model.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;

  typedef enum logic [1:0] {ACC_NONE, ACC_RW, ACC_RO, ACC_WO} acc_e;
  typedef enum logic [1:0] {RO_LOCK, RO_PLLSTA, RO_BOOT, RO_ID} ro_e;

  // byte offsets whose positions are part of the behaviour
  localparam int unsigned OFF_SCRATCH = 32'h000;
  localparam int unsigned OFF_LOCK    = 32'h004;
  localparam int unsigned OFF_UNLOCK  = 32'h008;
  localparam int unsigned OFF_LOCKSTA = 32'h00C;
  localparam int unsigned OFF_PLL0    = 32'h100;
  localparam int unsigned OFF_PLL1    = 32'h104;
  localparam int unsigned OFF_PLL2    = 32'h108;
  localparam int unsigned OFF_PLLSTA  = 32'h10C;
  localparam int unsigned OFF_UARTCK  = 32'h154;
  localparam int unsigned OFF_RSTCTL  = 32'h200;
  localparam int unsigned OFF_BOOT    = 32'h25C;
  localparam int unsigned OFF_ID      = 32'h530;
  localparam int unsigned OFF_CALGO   = 32'h60C;
  localparam int unsigned OFF_REFGO   = 32'h614;

  localparam logic [15:0] KEY_CLOSE = 16'h767B;
  localparam logic [15:0] KEY_OPEN  = 16'hDF0D;

  // storage slot numbering
  localparam int SL_SCRATCH = 0;
  localparam int SL_PLL0    = 1;
  localparam int SL_UART    = 4;
  localparam int SL_RST     = 5;
  localparam int SL_GP0     = 6;

  localparam logic [31:0] RST_PLL  = 32'h0001_A008;
  localparam logic [31:0] RST_UART = 32'h0000_3F03;

  function automatic logic [31:0] slot_reset(int k);
    if (k >= SL_PLL0 && k < SL_PLL0 + 3) return RST_PLL;
    if (k == SL_UART) return RST_UART;
    return 32'h0;
  endfunction

endpackage

// File: rtl/ctl_rb_decode.sv
module ctl_rb_decode
  import ctl_regbank_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int GP_BASE  = 32'h700,
  parameter int GP_COUNT = 8,
  parameter int SLOT_W   = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_e              cls_o,
  output logic [SLOT_W-1:0] slot_o,
  output ro_e               ro_o,
  output logic              lock_o,
  output logic              unlock_o
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_SCRATCH = WORD_W'(OFF_SCRATCH >> 2);
  localparam logic [WORD_W-1:0] W_LOCK    = WORD_W'(OFF_LOCK >> 2);
  localparam logic [WORD_W-1:0] W_UNLOCK  = WORD_W'(OFF_UNLOCK >> 2);
  localparam logic [WORD_W-1:0] W_LOCKSTA = WORD_W'(OFF_LOCKSTA >> 2);
  localparam logic [WORD_W-1:0] W_PLL0    = WORD_W'(OFF_PLL0 >> 2);
  localparam logic [WORD_W-1:0] W_PLL1    = WORD_W'(OFF_PLL1 >> 2);
  localparam logic [WORD_W-1:0] W_PLL2    = WORD_W'(OFF_PLL2 >> 2);
  localparam logic [WORD_W-1:0] W_PLLSTA  = WORD_W'(OFF_PLLSTA >> 2);
  localparam logic [WORD_W-1:0] W_UARTCK  = WORD_W'(OFF_UARTCK >> 2);
  localparam logic [WORD_W-1:0] W_RSTCTL  = WORD_W'(OFF_RSTCTL >> 2);
  localparam logic [WORD_W-1:0] W_BOOT    = WORD_W'(OFF_BOOT >> 2);
  localparam logic [WORD_W-1:0] W_ID      = WORD_W'(OFF_ID >> 2);
  localparam logic [WORD_W-1:0] W_CALGO   = WORD_W'(OFF_CALGO >> 2);
  localparam logic [WORD_W-1:0] W_REFGO   = WORD_W'(OFF_REFGO >> 2);
  localparam logic [WORD_W:0]   GP_LO     = (WORD_W+1)'(GP_BASE >> 2);
  localparam logic [WORD_W:0]   GP_HI     = (WORD_W+1)'((GP_BASE >> 2) + GP_COUNT);

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] gp_idx;

  assign word   = addr_i[ADDR_W-1:2];
  assign gp_idx = word - GP_LO[WORD_W-1:0];

  always_comb begin
    cls_o    = ACC_NONE;
    slot_o   = '0;
    ro_o     = RO_LOCK;
    lock_o   = 1'b0;
    unlock_o = 1'b0;
    if (addr_i[1:0] == 2'b00) begin
      if ({1'b0, word} >= GP_LO && {1'b0, word} < GP_HI) begin
        cls_o  = ACC_RW;
        slot_o = SLOT_W'(SL_GP0) + SLOT_W'(gp_idx);
      end else begin
        case (word)
          W_SCRATCH: begin cls_o = ACC_RW; slot_o = SLOT_W'(SL_SCRATCH); end
          W_LOCK:    begin cls_o = ACC_WO; lock_o = 1'b1; end
          W_UNLOCK:  begin cls_o = ACC_WO; unlock_o = 1'b1; end
          W_LOCKSTA: begin cls_o = ACC_RO; ro_o = RO_LOCK; end
          W_PLL0:    begin cls_o = ACC_RW; slot_o = SLOT_W'(SL_PLL0); end
          W_PLL1:    begin cls_o = ACC_RW; slot_o = SLOT_W'(SL_PLL0 + 1); end
          W_PLL2:    begin cls_o = ACC_RW; slot_o = SLOT_W'(SL_PLL0 + 2); end
          W_PLLSTA:  begin cls_o = ACC_RO; ro_o = RO_PLLSTA; end
          W_UARTCK:  begin cls_o = ACC_RW; slot_o = SLOT_W'(SL_UART); end
          W_RSTCTL:  begin cls_o = ACC_RW; slot_o = SLOT_W'(SL_RST); end
          W_BOOT:    begin cls_o = ACC_RO; ro_o = RO_BOOT; end
          W_ID:      begin cls_o = ACC_RO; ro_o = RO_ID; end
          W_CALGO:   cls_o = ACC_WO;
          W_REFGO:   cls_o = ACC_WO;
          default:   cls_o = ACC_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctl_rb_keylock.sv
module ctl_rb_keylock
  import ctl_regbank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        close_wr_i,
  input  logic        open_wr_i,
  input  logic [15:0] key_i,
  output logic        locked_o
);
  logic close_hit, open_hit;

  assign close_hit = close_wr_i && (key_i == KEY_CLOSE);
  assign open_hit  = open_wr_i  && (key_i == KEY_OPEN);

  always_ff @(posedge clk) begin
    if (!rst_n)         locked_o <= 1'b1;
    else if (close_hit) locked_o <= 1'b1;
    else if (open_hit)  locked_o <= 1'b0;
  end

  p_close_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (close_wr_i && key_i == KEY_CLOSE) |=> locked_o);
  p_open_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (open_wr_i && key_i == KEY_OPEN && !close_wr_i) |=> !locked_o);
  p_bad_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(close_wr_i && key_i == KEY_CLOSE) && !(open_wr_i && key_i == KEY_OPEN)
    |=> $stable(locked_o));
endmodule

// File: rtl/ctl_rb_store.sv
module ctl_rb_store
  import ctl_regbank_pkg::*;
#(
  parameter int NUM_SLOTS = 14,
  parameter int SLOT_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_i,
  input  logic [SLOT_W-1:0]          slot_i,
  input  logic [31:0]                wdata_i,
  input  logic                       lock_i,
  output logic [NUM_SLOTS-1:0][31:0] q_o
);
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    logic hit;
    assign hit = wr_i && (slot_i == SLOT_W'(k));
    if (k == SL_SCRATCH) begin : g_bit
      // single bit, writable regardless of the lock
      always_ff @(posedge clk) begin
        if (!rst_n)   q_o[k] <= 32'h0;
        else if (hit) q_o[k] <= {31'h0, wdata_i[0]};
      end
      p_scratch_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (q_o[k][0] == $past(wdata_i[0])));
    end else begin : g_word
      always_ff @(posedge clk) begin
        if (!rst_n)              q_o[k] <= slot_reset(k);
        else if (hit && !lock_i) q_o[k] <= wdata_i;
      end
      p_locked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> $stable(q_o[k]));
    end
  end
endmodule

// File: rtl/ctl_keyed_regbank.sv
module ctl_keyed_regbank
  import ctl_regbank_pkg::*;
#(
  parameter int          ADDR_W       = 12,
  parameter int          GP_BASE      = 32'h700,
  parameter int          GP_COUNT     = 8,
  parameter logic [31:0] ID_VALUE     = 32'h1372_0093,
  parameter logic [31:0] BOOT_VALUE   = 32'h0000_0001,
  parameter logic [31:0] PLLSTA_VALUE = 32'h0000_003F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              soft_rst_req
);
  localparam int NUM_SLOTS = SL_GP0 + GP_COUNT;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  acc_e              cls;
  ro_e               ro_sel;
  logic [SLOT_W-1:0] slot;
  logic              at_lock, at_unlock;
  logic              is_wr, is_rd, bad, locked, rw_wr, srst_d;
  logic [31:0]       rd_val;
  logic [NUM_SLOTS-1:0][31:0] q;

  ctl_rb_decode #(
    .ADDR_W(ADDR_W), .GP_BASE(GP_BASE), .GP_COUNT(GP_COUNT), .SLOT_W(SLOT_W)
  ) u_dec (
    .addr_i(req_addr), .cls_o(cls), .slot_o(slot), .ro_o(ro_sel),
    .lock_o(at_lock), .unlock_o(at_unlock)
  );

  assign is_wr = req_valid && req_write;
  assign is_rd = req_valid && !req_write;
  assign bad   = req_valid && ((cls == ACC_NONE) ||
                               (is_rd && cls == ACC_WO) ||
                               (is_wr && cls == ACC_RO));
  assign rw_wr = is_wr && (cls == ACC_RW);

  ctl_rb_keylock u_key (
    .clk(clk), .rst_n(rst_n),
    .close_wr_i(is_wr && at_lock), .open_wr_i(is_wr && at_unlock),
    .key_i(req_wdata[15:0]), .locked_o(locked)
  );

  ctl_rb_store #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_i(rw_wr), .slot_i(slot),
    .wdata_i(req_wdata), .lock_i(locked), .q_o(q)
  );

  assign srst_d = rw_wr && (slot == SLOT_W'(SL_RST)) && !locked && req_wdata[0];

  always_comb begin
    rd_val = 32'h0;
    if (is_rd) begin
      case (cls)
        ACC_RW: rd_val = q[slot];
        ACC_RO: begin
          case (ro_sel)
            RO_LOCK:   rd_val = {31'h0, locked};
            RO_PLLSTA: rd_val = PLLSTA_VALUE;
            RO_BOOT:   rd_val = BOOT_VALUE;
            default:   rd_val = ID_VALUE;
          endcase
        end
        default: rd_val = 32'h0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_err      <= 1'b0;
      rsp_rdata    <= 32'h0;
      soft_rst_req <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_err      <= bad;
      rsp_rdata    <= rd_val;
      soft_rst_req <= srst_d;
    end
  end

  p_resp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !soft_rst_req));
  p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == 32'h0));
  p_srst_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req |-> ($past(!locked) && rsp_valid && !rsp_err));
endmodule

// File: tb/ctl_keyed_regbank_test.sv
module ctl_keyed_regbank_test;
  localparam logic [31:0] ID = 32'h1372_0093;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err, soft_rst_req;
  logic [31:0] rsp_rdata;

  int n_checks = 0;
  int n_fail = 0;

  // bench model
  logic        m_locked;
  logic        m_scr;
  logic [31:0] m_pll [3];
  logic [31:0] m_uart, m_rst;
  logic [31:0] m_gp [8];

  always #2 clk = ~clk;

  ctl_keyed_regbank #(.ID_VALUE(ID)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .soft_rst_req(soft_rst_req)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // 0 unmapped, 1 read-write, 2 read-only, 3 write-only
  function automatic int cls_of(logic [11:0] a);
    if (a[1:0] != 2'b00) return 0;
    if (a >= 12'h700 && a < 12'h720) return 1;
    case (a)
      12'h000, 12'h100, 12'h104, 12'h108, 12'h154, 12'h200: return 1;
      12'h00C, 12'h10C, 12'h25C, 12'h530: return 2;
      12'h004, 12'h008, 12'h60C, 12'h614: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] read_model(logic [11:0] a);
    if (a >= 12'h700 && a < 12'h720) return m_gp[(a - 12'h700) >> 2];
    case (a)
      12'h000: return {31'h0, m_scr};
      12'h100: return m_pll[0];
      12'h104: return m_pll[1];
      12'h108: return m_pll[2];
      12'h154: return m_uart;
      12'h200: return m_rst;
      12'h00C: return {31'h0, m_locked};
      12'h10C: return 32'h3F;
      12'h25C: return 32'h1;
      12'h530: return ID;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    if (a == 12'h004) begin if (d[15:0] == 16'h767B) m_locked = 1'b1; end
    else if (a == 12'h008) begin if (d[15:0] == 16'hDF0D) m_locked = 1'b0; end
    else if (a == 12'h000) m_scr = d[0];
    else if (!m_locked) begin
      if (a >= 12'h700 && a < 12'h720) m_gp[(a - 12'h700) >> 2] = d;
      else if (a == 12'h100) m_pll[0] = d;
      else if (a == 12'h104) m_pll[1] = d;
      else if (a == 12'h108) m_pll[2] = d;
      else if (a == 12'h154) m_uart = d;
      else if (a == 12'h200) m_rst = d;
    end
  endtask

  task automatic acc(input logic w, input logic [11:0] a, input logic [31:0] d,
                     input string tag);
    int c;
    logic ee, es;
    logic [31:0] er;
    c  = cls_of(a);
    ee = (c == 0) || (!w && c == 3) || (w && c == 2);
    er = (!w && !ee) ? read_model(a) : 32'h0;
    es = w && (a == 12'h200) && !m_locked && d[0];
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    check(tag, "rsp_valid", {31'h0, rsp_valid}, 32'h1);
    check(tag, "rsp_err", {31'h0, rsp_err}, {31'h0, ee});
    check(tag, "rsp_rdata", rsp_rdata, er);
    check(tag, "soft_rst_req", {31'h0, soft_rst_req}, {31'h0, es});
    if (w && !ee) model_write(a, d);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk); req_valid = 1'b0;
    @(posedge clk); #1;
    check(tag, "idle rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check(tag, "idle soft_rst_req", {31'h0, soft_rst_req}, 32'h0);
  endtask

  function automatic logic [11:0] pick_addr(int r);
    case (r % 20)
      0: return 12'h000;  1: return 12'h004;  2: return 12'h008;
      3: return 12'h00C;  4: return 12'h100;  5: return 12'h104;
      6: return 12'h108;  7: return 12'h10C;  8: return 12'h154;
      9: return 12'h200; 10: return 12'h25C; 11: return 12'h530;
      12: return 12'h60C; 13: return 12'h614;
      14, 15: return 12'h700 + 12'((r >> 5) % 8) * 12'h4;
      16: return 12'h004;  17: return 12'h008;
      default: return 12'($urandom);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_locked = 1'b1; m_scr = 1'b0;
    for (int i = 0; i < 3; i++) m_pll[i] = 32'h0001_A008;
    m_uart = 32'h0000_3F03; m_rst = 32'h0;
    for (int i = 0; i < 8; i++) m_gp[i] = 32'h0;

    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check("R1", "reset soft_rst_req", {31'h0, soft_rst_req}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset values
    acc(1'b0, 12'h100, 32'h0, "R1");
    acc(1'b0, 12'h104, 32'h0, "R1");
    acc(1'b0, 12'h108, 32'h0, "R1");
    acc(1'b0, 12'h154, 32'h0, "R1");
    acc(1'b0, 12'h200, 32'h0, "R1");
    acc(1'b0, 12'h000, 32'h0, "R1");
    acc(1'b0, 12'h71C, 32'h0, "R1");
    acc(1'b0, 12'h00C, 32'h0, "R5");
    idle_check("R2");

    // R6 locked writes dropped, R7 scratch always open
    acc(1'b1, 12'h100, 32'hDEAD_BEEF, "R6");
    acc(1'b0, 12'h100, 32'h0, "R6");
    acc(1'b1, 12'h704, 32'h1234_5678, "R6");
    acc(1'b0, 12'h704, 32'h0, "R6");
    acc(1'b1, 12'h000, 32'hFFFF_FFFF, "R7");
    acc(1'b0, 12'h000, 32'h0, "R7");
    acc(1'b1, 12'h200, 32'h1, "R11");
    acc(1'b0, 12'h200, 32'h0, "R11");

    // R4 unlock keys
    acc(1'b1, 12'h008, 32'h0000_767B, "R4");
    acc(1'b0, 12'h00C, 32'h0, "R4");
    acc(1'b1, 12'h008, 32'h1234_DF0D, "R4");
    acc(1'b0, 12'h00C, 32'h0, "R4");

    // R3 lock keys
    acc(1'b1, 12'h004, 32'h0000_DF0D, "R3");
    acc(1'b0, 12'h00C, 32'h0, "R3");
    acc(1'b1, 12'h154, 32'h0000_0A5A, "R6");
    acc(1'b0, 12'h154, 32'h0, "R6");

    // R11 soft reset pulse
    acc(1'b1, 12'h200, 32'h0000_0003, "R11");
    idle_check("R11");
    acc(1'b0, 12'h200, 32'h0, "R11");
    acc(1'b0, 12'h154, 32'h0, "R11");
    acc(1'b1, 12'h200, 32'h0000_0002, "R11");

    // R8 write-only, R9 read-only, R10 unmapped, R12 misaligned
    acc(1'b0, 12'h004, 32'h0, "R8");
    acc(1'b0, 12'h008, 32'h0, "R8");
    acc(1'b0, 12'h60C, 32'h0, "R8");
    acc(1'b1, 12'h614, 32'h1, "R8");
    acc(1'b0, 12'h10C, 32'h0, "R9");
    acc(1'b0, 12'h25C, 32'h0, "R9");
    acc(1'b0, 12'h530, 32'h0, "R9");
    acc(1'b1, 12'h10C, 32'hFFFF_FFFF, "R9");
    acc(1'b1, 12'h00C, 32'h0, "R9");
    acc(1'b0, 12'h00C, 32'h0, "R9");
    acc(1'b0, 12'h800, 32'h0, "R10");
    acc(1'b1, 12'hFFC, 32'h5, "R10");
    acc(1'b0, 12'h720, 32'h0, "R10");
    acc(1'b0, 12'h101, 32'h0, "R12");
    acc(1'b1, 12'h202, 32'h1, "R12");
    acc(1'b0, 12'h100, 32'h0, "R12");

    // R3 lock with upper bits set, then locked behaviour
    acc(1'b1, 12'h004, 32'hABCD_767B, "R3");
    acc(1'b0, 12'h00C, 32'h0, "R3");
    acc(1'b1, 12'h200, 32'h1, "R11");

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int r;
      logic [11:0] a;
      logic [31:0] d;
      int c;
      string tag;
      r = int'($urandom);
      a = pick_addr(r >> 3);
      d = $urandom;
      if ((r & 3) == 1) d[15:0] = 16'h767B;
      if ((r & 3) == 2) d[15:0] = 16'hDF0D;
      c = cls_of(a);
      tag = (c == 1) ? "R6" : (c == 2) ? "R9" : (c == 3) ? "R8" : "R10";
      if (a == 12'h200) tag = "R11";
      acc(r[2], a, d, tag);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule